// File: doc/BRIEF.md
# Miss-Triggered Thread Switch Controller

This block sequences coarse-grain multithreading on an in-order pipeline. One hardware context owns the pipeline at a time. It keeps running until it reports a long-latency cache miss. The controller then asks the pipeline to flush and stalls fetch for a fixed switch penalty. When the penalty has elapsed and the pipeline reports that it has drained, the controller hands the pipeline to the next context that is ready to run.

Each context that misses is held back until its own resolved signal arrives. The PC of the instruction that missed is recorded for that context. That PC is presented as the restart address whenever the context is later selected again. If every context is waiting, the controller parks in an idle state with fetch stalled. It resumes as soon as any context is released. The number of contexts is a parameter, meant to be 2 or 4.

Top module: `mt_switch_ctrl`

## Requirements
- R1: After reset, context 0 is active, fetch_stall, flush_req and restart_load are low, and every context is ready to run from address 0.
- R2: A miss reported while running, tagged with the active context, raises flush_req and fetch_stall in the next cycle. flush_req is a single-cycle pulse for each switch.
- R3: With drained held high, fetch_stall stays high for exactly PENALTY cycles (default 4) per switch, and never fewer.
- R4: A switch does not finish until drained has been seen high at least once while switching. A drained pulse early in the penalty window is remembered, and a late drained ends the switch on the following clock edge.
- R5: A context that missed is not selected again until its bit of ctx_resolved has been pulsed.
- R6: At the end of a switch, the new active context is the first ready context found counting upward from the previous one, with wrap-around. The previous context is considered last. active_tid does not change while fetch is not stalled.
- R7: If no context is ready when a switch ends, fetch_stall stays high and nothing is restarted. Two cycles after a ctx_resolved pulse, that context starts running.
- R8: In the first running cycle after a switch, restart_load pulses for one cycle. restart_pc then holds the miss PC last recorded for the new active context, or 0 if it never missed.
- R9: A miss reported while a switch is in progress is ignored. It causes no further flush and does not overwrite the saved restart PC.
- R10: A miss tagged with a context other than the active one is ignored. No flush starts and the active context is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Long-latency cache miss reported this cycle |
| miss_tid | input | TID_W | Context that took the miss |
| miss_pc | input | PC_W | PC of the oldest instruction that will be flushed |
| ctx_resolved | input | NUM_CTX | One bit per context: its outstanding miss is resolved |
| drained | input | 1 | Pipeline reports no instructions of the old context in flight |
| active_tid | output | TID_W | Context that currently owns the pipeline |
| flush_req | output | 1 | One-cycle request to flush the pipeline |
| fetch_stall | output | 1 | Fetch must not issue (switch in progress or idle) |
| restart_load | output | 1 | Load restart_pc into the fetch PC this cycle |
| restart_pc | output | PC_W | Restart address of the active context |

## Verification
A corrupted ready bit shows up at the end of the next switch, as a wrong active_tid beside restart_load or as a stall that never ends. A lost saved PC shows up only when its context is restarted, so the scoreboard compares every restart against the context and address the requirements predict. A fault in the penalty counter or the drain latch changes the length of the fetch_stall window. That window is counted cycle by cycle on every switch, with drained high, pulsed early and raised late. A miss accepted at the wrong time appears as a second flush_req pulse within the same switch.

// File: rtl/mt_switch_pkg.sv
// Shared types for the thread switch controller.
package mt_switch_pkg;
    // Sequencer phases: running a context, flushing/switching, or parked.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SWITCH = 2'd1,
        ST_IDLE   = 2'd2
    } sw_state_e;
endpackage

// File: rtl/ctx_wait_tracker.sv
// Keeps one "waiting on miss" bit per hardware context.
// Assumes set and resolve for the same context in one cycle means a new miss,
// so set takes priority.
module ctx_wait_tracker #(
    parameter int NUM_CTX = 4,
    localparam int TID_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [TID_W-1:0]   set_tid,
    input  logic [NUM_CTX-1:0] resolve,
    output logic [NUM_CTX-1:0] waiting
);
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        // Per-context waiting flag: set on accepted miss, cleared on resolve.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                waiting[c] <= 1'b0;
            end else if (set_en && (set_tid == TID_W'(c))) begin
                waiting[c] <= 1'b1;
            end else if (resolve[c]) begin
                waiting[c] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rr_ctx_picker.sv
// Combinational round-robin pick of the next ready context.
// Searches upward from the context after cur_tid, wrapping, and tests
// cur_tid itself last.
module rr_ctx_picker #(
    parameter int NUM_CTX = 4,
    localparam int TID_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic [TID_W-1:0]   cur_tid,
    input  logic [NUM_CTX-1:0] waiting,
    output logic               found,
    output logic [TID_W-1:0]   next_tid
);
    // First non-waiting context in rotating order.
    always_comb begin
        found    = 1'b0;
        next_tid = '0;
        for (int off = 1; off <= NUM_CTX; off++) begin
            int idx;
            idx = (int'(cur_tid) + off) % NUM_CTX;
            if (!found && !waiting[idx]) begin
                found    = 1'b1;
                next_tid = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/switch_sequencer.sv
// Run / switch / idle state machine with the penalty counter.
// A miss is accepted only while running and only when it is tagged with the
// active context. The switch lasts at least PENALTY cycles and ends once
// drained has been observed.
module switch_sequencer
    import mt_switch_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int PENALTY = 4,
    localparam int TID_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int CNT_W = (PENALTY > 1) ? $clog2(PENALTY) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [TID_W-1:0] miss_tid,
    input  logic             drained,
    input  logic             pick_found,
    input  logic [TID_W-1:0] pick_tid,
    output logic             miss_accept,
    output logic [TID_W-1:0] active_tid,
    output logic             flush_req,
    output logic             fetch_stall,
    output logic             restart_load
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PENALTY - 1);

    sw_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             drain_seen_q;

    // Miss qualification: running phase and tagged with the owner.
    assign miss_accept = (state_q == ST_RUN) && miss_valid && (miss_tid == active_tid);

    // Phase transitions, penalty count and active context update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            cnt_q        <= '0;
            drain_seen_q <= 1'b0;
            active_tid   <= '0;
            restart_load <= 1'b0;
        end else begin
            restart_load <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (miss_accept) begin
                        state_q      <= ST_SWITCH;
                        cnt_q        <= '0;
                        drain_seen_q <= 1'b0;
                    end
                end
                ST_SWITCH: begin
                    if (drained) drain_seen_q <= 1'b1;
                    if (cnt_q != CNT_LAST) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (drained || drain_seen_q) begin
                        if (pick_found) begin
                            state_q      <= ST_RUN;
                            active_tid   <= pick_tid;
                            restart_load <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (pick_found) begin
                        state_q      <= ST_RUN;
                        active_tid   <= pick_tid;
                        restart_load <= 1'b1;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Flush request in the first switch cycle; stall outside the run phase.
    assign flush_req   = (state_q == ST_SWITCH) && (cnt_q == '0);
    assign fetch_stall = (state_q != ST_RUN);
endmodule

// File: rtl/mt_switch_ctrl.sv
// Coarse-grain thread switch controller: on a cache miss in the running
// context it flushes the pipeline, stalls fetch for the switch penalty and
// selects the next ready context round-robin. It saves the missing PC per
// context for restart. Assumes NUM_CTX is 2 or 4 and that miss_pc is the PC
// of the oldest instruction the flush discards.
module mt_switch_ctrl #(
    parameter int NUM_CTX = 4,
    parameter int PENALTY = 4,
    parameter int PC_W    = 32,
    localparam int TID_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [TID_W-1:0]   miss_tid,
    input  logic [PC_W-1:0]    miss_pc,
    input  logic [NUM_CTX-1:0] ctx_resolved,
    input  logic               drained,
    output logic [TID_W-1:0]   active_tid,
    output logic               flush_req,
    output logic               fetch_stall,
    output logic               restart_load,
    output logic [PC_W-1:0]    restart_pc
);
    logic               miss_accept;
    logic [NUM_CTX-1:0] waiting;
    logic               pick_found;
    logic [TID_W-1:0]   pick_tid;
    logic [PC_W-1:0]    saved_pc [NUM_CTX];

    ctx_wait_tracker #(.NUM_CTX(NUM_CTX)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (miss_accept),
        .set_tid (miss_tid),
        .resolve (ctx_resolved),
        .waiting (waiting)
    );

    rr_ctx_picker #(.NUM_CTX(NUM_CTX)) u_pick (
        .cur_tid  (active_tid),
        .waiting  (waiting),
        .found    (pick_found),
        .next_tid (pick_tid)
    );

    switch_sequencer #(.NUM_CTX(NUM_CTX), .PENALTY(PENALTY)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_tid     (miss_tid),
        .drained      (drained),
        .pick_found   (pick_found),
        .pick_tid     (pick_tid),
        .miss_accept  (miss_accept),
        .active_tid   (active_tid),
        .flush_req    (flush_req),
        .fetch_stall  (fetch_stall),
        .restart_load (restart_load)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_pc
        // Restart address of one context, captured on its accepted miss.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_pc[c] <= '0;
            end else if (miss_accept && (miss_tid == TID_W'(c))) begin
                saved_pc[c] <= miss_pc;
            end
        end
    end

    // Restart address follows the active context.
    assign restart_pc = saved_pc[active_tid];
endmodule

// File: rtl/mt_switch_ctrl_chk.sv
// Port-level temporal checks on the thread switch controller, bound to it.
// A counter measures each stall window, so the penalty check needs no deep
// $past.
module mt_switch_ctrl_chk #(
    parameter int NUM_CTX = 4,
    parameter int PENALTY = 4,
    localparam int TID_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic [TID_W-1:0] miss_tid,
    input logic [TID_W-1:0] active_tid,
    input logic             flush_req,
    input logic             fetch_stall,
    input logic             restart_load
);
    logic [7:0] stall_len;

    // Length of the current stall window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_len <= '0;
        else if (fetch_stall) stall_len <= (stall_len == 8'hFF) ? stall_len : stall_len + 1'b1;
        else stall_len <= '0;
    end

    p_miss_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && miss_valid && miss_tid == active_tid) |=> (flush_req && fetch_stall));

    p_flush_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    p_min_penalty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_stall) |-> (stall_len >= 8'(PENALTY)));

    p_run_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stall |=> (fetch_stall || $stable(active_tid)));

    p_restart_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_load |-> (!fetch_stall && $past(fetch_stall)));

    p_flush_from_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !$past(fetch_stall));

    p_other_tid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && miss_valid && miss_tid != active_tid) |=> !flush_req);
endmodule

bind mt_switch_ctrl mt_switch_ctrl_chk #(.NUM_CTX(NUM_CTX), .PENALTY(PENALTY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_tid     (miss_tid),
    .active_tid   (active_tid),
    .flush_req    (flush_req),
    .fetch_stall  (fetch_stall),
    .restart_load (restart_load)
);

// File: tb/mt_switch_ctrl_tb.sv
// Scoreboard bench: driver tasks keep a requirement-level model of ready bits
// and saved PCs and queue the expected restarts; a monitor compares them.
module mt_switch_ctrl_tb_top;
    localparam int NC = 4;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [1:0]    miss_tid = '0;
    logic [PW-1:0] miss_pc = '0;
    logic [NC-1:0] ctx_resolved = '0;
    logic          drained = 1'b1;
    logic [1:0]    active_tid;
    logic          flush_req, fetch_stall, restart_load;
    logic [PW-1:0] restart_pc;

    int checks = 0;
    int errors = 0;
    int q_tid[$];
    int q_pc[$];
    logic [NC-1:0] m_wait = '0;
    int m_pc[NC] = '{default: 0};
    int m_active = 0;
    bit m_idle = 1'b0;

    mt_switch_ctrl #(.NUM_CTX(NC), .PENALTY(4), .PC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_tid(miss_tid),
        .miss_pc(miss_pc), .ctx_resolved(ctx_resolved), .drained(drained),
        .active_tid(active_tid), .flush_req(flush_req), .fetch_stall(fetch_stall),
        .restart_load(restart_load), .restart_pc(restart_pc)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model: first ready context after cur, cur itself last (R6).
    function automatic int pick(input int cur);
        for (int off = 1; off <= NC; off++) begin
            if (!m_wait[(cur + off) % NC]) return (cur + off) % NC;
        end
        return -1;
    endfunction

    // Monitor: every restart must match the next scoreboard entry (R8, R6).
    always @(negedge clk) begin
        if (rst_n && restart_load) begin
            if (q_tid.size() == 0) begin
                check(1'b0, "R7 unexpected restart", int'(active_tid), -1);
            end else begin
                int et, ep;
                et = q_tid.pop_front();
                ep = q_pc.pop_front();
                check(int'(active_tid) == et, "R6 next context", int'(active_tid), et);
                check(int'(restart_pc) == ep, "R8 restart pc", int'(restart_pc), ep);
            end
        end
    end

    // Drive a miss and follow the switch. mode: 0 drained high, 1 early pulse, 2 late.
    task automatic run_switch(input int tid, input int pc, input int mode,
                              input bit bogus, input int exp_stall);
        int nstall, nflush, nxt;
        @(negedge clk);
        miss_valid = 1'b1; miss_tid = 2'(tid); miss_pc = PW'(pc);
        drained = (mode == 0);
        m_wait[tid] = 1'b1; m_pc[tid] = pc;
        nxt = pick(tid);
        if (nxt >= 0) begin
            q_tid.push_back(nxt); q_pc.push_back(m_pc[nxt]); m_active = nxt;
        end else begin
            m_idle = 1'b1;
        end
        @(negedge clk);
        miss_valid = bogus; miss_pc = PW'(32'h999);
        check(flush_req && fetch_stall, "R2 flush after miss", {flush_req, fetch_stall}, 3);
        nstall = 0; nflush = 0;
        while (fetch_stall && nstall < 12) begin
            nstall++;
            if (flush_req) nflush++;
            if (mode == 1) drained = (nstall == 1);
            if (mode == 2) drained = (nstall >= 8);
            if (bogus) miss_valid = (nstall < 3);
            @(negedge clk);
        end
        miss_valid = 1'b0; drained = 1'b1;
        if (nxt < 0) begin
            check(fetch_stall == 1'b1, "R7 idle keeps stall", fetch_stall, 1);
        end else begin
            check(nstall == exp_stall, (mode == 0) ? "R3 penalty" : "R4 drain wait", nstall, exp_stall);
        end
        check(nflush == 1, bogus ? "R9 single flush" : "R2 single flush", nflush, 1);
    endtask

    // Pulse resolve bits for one cycle and update the model.
    task automatic resolve(input logic [NC-1:0] bits);
        @(negedge clk);
        ctx_resolved = bits;
        m_wait = m_wait & ~bits;
        if (m_idle) begin
            int nxt;
            nxt = pick(m_active);
            q_tid.push_back(nxt); q_pc.push_back(m_pc[nxt]);
            m_active = nxt; m_idle = 1'b0;
        end
        @(negedge clk);
        ctx_resolved = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(active_tid == 0, "R1 active", int'(active_tid), 0);
        check(!fetch_stall && !flush_req && !restart_load, "R1 controls",
              {fetch_stall, flush_req, restart_load}, 0);

        // R3/R8: context 0 misses, context 1 starts at address 0.
        run_switch(0, 32'h100, 0, 1'b0, 4);

        // R10: miss tagged with another context is ignored.
        @(negedge clk);
        miss_valid = 1'b1; miss_tid = 2'd3; miss_pc = PW'(32'hBAD);
        @(negedge clk);
        miss_valid = 1'b0;
        check(!flush_req && !fetch_stall, "R10 no flush", {flush_req, fetch_stall}, 0);
        @(negedge clk);
        check(active_tid == 1 && !fetch_stall, "R10 active kept", int'(active_tid), 1);

        // R4: early drained pulse is remembered, late drained holds the switch.
        run_switch(1, 32'h200, 1, 1'b0, 4);
        run_switch(2, 32'h2A0, 2, 1'b0, 8);

        // R7/R5: all contexts waiting -> idle until a resolve.
        run_switch(3, 32'h3C0, 0, 1'b0, 0);
        @(negedge clk);
        ctx_resolved = 4'b0010;
        m_wait[1] = 1'b0;
        q_tid.push_back(1); q_pc.push_back(m_pc[1]); m_active = 1; m_idle = 1'b0;
        @(negedge clk);
        ctx_resolved = '0;
        check(fetch_stall == 1'b1, "R7 stall one cycle after resolve", fetch_stall, 1);
        @(negedge clk);
        check(fetch_stall == 1'b0, "R7 resume after resolve", fetch_stall, 0);

        // R5: resolving while running changes nothing visible.
        resolve(4'b0101);
        check(active_tid == 1 && !fetch_stall, "R5 no switch on resolve", int'(active_tid), 1);

        // R6/R9: round-robin prefers 2 over 0; misses during switch ignored.
        run_switch(1, 32'h300, 0, 1'b1, 4);
        // R5: context 3 still waiting, so 0 is chosen after 2.
        run_switch(2, 32'h400, 0, 1'b0, 4);
        resolve(4'b0010);
        // R9: context 1 restarts at 0x300, not the ignored 0x999.
        run_switch(0, 32'h500, 0, 1'b0, 4);

        repeat (3) @(negedge clk);
        check(q_tid.size() == 0, "R8 all restarts seen", q_tid.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule